// File: doc/BRIEF.md
# Asynchronous EPROM Bank Read Controller

This block lets a clocked host read single bytes from a bank of byte-wide asynchronous UV/OTP EPROM devices that share one address bus, one data bus and one output-enable strobe. Each device has its own active-low chip-enable. The host presents an address whose upper bits pick the device and whose low 19 bits pick the byte. The controller then drives the address and that device's chip-enable. It lowers the shared output-enable after a computed setup interval, waits out the output-enable access time, and captures the data bus. It returns the byte with a one-cycle valid pulse, raises both enables, and holds off the next access until the bus has floated.

All wait intervals are counted in clock cycles. Each count is the ceiling of a device timing divided by the clock period, plus one cycle of margin. The timings are the address and chip-enable access time (120 ns fast grade, 150 ns slow grade), the output-enable access time (60 ns or 80 ns) and the 50 ns float time. The clock period, the speed grade and the device count are parameters.

A signature read follows the same bus sequence. During the access the controller also asserts a request output, so that external hardware can apply the elevated identification voltage. The selected device then returns its identifier byte.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high and after it, with no access under way: every chip-enable is high, output-enable is high, `req_ready` is 1, `rsp_valid` is 0 and `id_volt_req` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access and its float interval end. Requests presented while `req_ready` is 0 have no effect on any output.
- R3: From the accepting edge, only the chip-enable of device `req_addr[AW-1:19]` is driven low (bit i of `mem_ce_n` belongs to device i). At most one chip-enable is low at any time.
- R4: `mem_addr` carries `req_addr[18:0]` from the accepting edge and stays stable while a chip-enable is low.
- R5: Output-enable falls exactly SETUP_CYC cycles after the accepting edge. SETUP_CYC = ceil((t_access − t_oe)/T_clk) + 1, which is 13 for a 5 ns clock and the fast grade (t_access 120 ns, t_oe 60 ns; slow grade 150 ns and 80 ns).
- R6: `rsp_valid` is a one-cycle pulse OE_CYC + 1 cycles after output-enable falls, with OE_CYC = ceil(t_oe/T_clk) + 1. The byte in `rsp_data` is the data bus value captured at that edge. Both enables rise at that same edge.
- R7: Output-enable is low only while some chip-enable is low.
- R8: `req_ready` returns FLT_CYC = ceil(50 ns/T_clk) + 1 cycles after the enables rise. No chip-enable falls sooner than FLT_CYC cycles after the enables last went high.
- R9: A request with `req_sig` = 1 holds `id_volt_req` high while its chip-enable is low. The byte returned is then 20h when address bit 0 is 0 and 41h when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | AW | Device select (upper bits) and byte address (low 19 bits) |
| req_sig | input | 1 | Request is a signature read |
| req_ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | One-cycle pulse, `rsp_data` is valid |
| rsp_data | output | 8 | Byte read |
| mem_addr | output | 19 | Shared device address bus |
| mem_ce_n | output | NDEV | Active-low chip-enable, one per device |
| mem_oe_n | output | 1 | Shared active-low output-enable |
| mem_data | input | 8 | Shared device data bus |
| id_volt_req | output | 1 | Request for the identification voltage |

## Verification
The bench builds the block with a 5 ns clock, the fast grade and four devices. This gives setup, output-enable and float counts of 13, 13 and 11 cycles. At these values a count that is one cycle short makes the behavioural device model return a corrupt byte, and the cycle-by-cycle reference model flags a wrongly timed strobe. Four devices bring every chip-enable decode into reach, including the top device at the highest byte address. Requests held high during busy intervals show that no request is taken early.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    localparam int DEV_AW = 19;
    localparam int DW     = 8;
    localparam int T_FLOAT_NS = 50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_OE_WAIT,
        ST_SAMPLE,
        ST_FLOAT
    } rd_state_e;

    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    // address / chip-enable access time per grade
    function automatic int t_acc_ns(input bit slow);
        return slow ? 150 : 120;
    endfunction

    function automatic int t_ce_ns(input bit slow);
        return slow ? 150 : 120;
    endfunction

    function automatic int t_oe_ns(input bit slow);
        return slow ? 80 : 60;
    endfunction

    // cycles covering ns, plus one cycle of margin
    function automatic int wait_cycles(input int ns, input int clk_ns);
        return ((ns > 0) ? ceil_div(ns, clk_ns) : 0) + 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5 R6 R8: an expired count stays expired until reloaded
    a_r5_timer_holds_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/eprom_rd_ce_decode.sv
module eprom_rd_ce_decode #(
    parameter int NDEV  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open,
    input  logic             close,
    input  logic [SEL_W-1:0] sel,
    output logic [NDEV-1:0]  ce_n
);
    for (genvar g = 0; g < NDEV; g++) begin : g_ce
        always_ff @(posedge clk) begin
            if (rst)
                ce_n[g] <= 1'b1;
            else if (close)
                ce_n[g] <= 1'b1;
            else if (open)
                ce_n[g] <= (sel != SEL_W'(g));
        end
    end

    a_r3_ce_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));

    a_r3_open_selects: assert property (@(posedge clk) disable iff (rst)
        (open && !close) |=> !ce_n[$past(sel)]);

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int NDEV      = 4,
    parameter int SEL_W     = 2,
    parameter int AW        = 21,
    parameter int CNT_W     = 5,
    parameter int SETUP_CYC = 13,
    parameter int OE_CYC    = 13,
    parameter int FLT_CYC   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_sig,
    output logic              req_ready,
    input  logic              timer_done,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              sel_open,
    output logic              sel_close,
    output logic [SEL_W-1:0]  sel_idx,
    output logic [DEV_AW-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              id_volt_req,
    input  logic [DW-1:0]     mem_data,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data
);
    rd_state_e state_q, state_d;
    logic      accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign sel_idx   = req_addr[AW-1 -: SEL_W];

    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        sel_open   = 1'b0;
        sel_close  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d    = ST_SETUP;
                timer_load = 1'b1;
                timer_val  = CNT_W'(SETUP_CYC - 1);
                sel_open   = 1'b1;
            end
            ST_SETUP: if (timer_done) begin
                state_d    = ST_OE_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(OE_CYC - 1);
            end
            ST_OE_WAIT: if (timer_done)
                state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                state_d    = ST_FLOAT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(FLT_CYC - 1);
                sel_close  = 1'b1;
            end
            ST_FLOAT: if (timer_done)
                state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mem_addr    <= '0;
            mem_oe_n    <= 1'b1;
            id_volt_req <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= 1'b0;
            if (accept) begin
                mem_addr    <= req_addr[DEV_AW-1:0];
                id_volt_req <= req_sig;
            end
            if (state_q == ST_SETUP && timer_done)
                mem_oe_n <= 1'b0;
            if (state_q == ST_SAMPLE) begin
                rsp_data    <= mem_data;
                rsp_valid   <= 1'b1;
                mem_oe_n    <= 1'b1;
                id_volt_req <= 1'b0;
            end
        end
    end

    a_r6_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r6_oe_rises_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> mem_oe_n);

    a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (!req_ready) |=> !$rose(mem_oe_n) || rsp_valid);

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_NS     = 5,
    parameter bit SPEED_SLOW = 1'b0,
    parameter int NDEV       = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic [DEV_AW+$clog2(NDEV)-1:0] req_addr,
    input  logic                           req_sig,
    output logic                           req_ready,
    output logic                           rsp_valid,
    output logic [7:0]                     rsp_data,
    output logic [18:0]                    mem_addr,
    output logic [NDEV-1:0]                mem_ce_n,
    output logic                           mem_oe_n,
    input  logic [7:0]                     mem_data,
    output logic                           id_volt_req
);
    localparam int SEL_W     = $clog2(NDEV);
    localparam int AW        = DEV_AW + SEL_W;
    localparam int T_LEAD_NS = max2(t_acc_ns(SPEED_SLOW), t_ce_ns(SPEED_SLOW))
                               - t_oe_ns(SPEED_SLOW);
    localparam int SETUP_CYC = wait_cycles(T_LEAD_NS, CLK_NS);
    localparam int OE_CYC    = wait_cycles(t_oe_ns(SPEED_SLOW), CLK_NS);
    localparam int FLT_CYC   = wait_cycles(T_FLOAT_NS, CLK_NS);
    localparam int MAX_CYC   = max2(max2(SETUP_CYC, OE_CYC), FLT_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic             sel_open, sel_close;
    logic [SEL_W-1:0] sel_idx;

    eprom_rd_seq #(
        .NDEV(NDEV), .SEL_W(SEL_W), .AW(AW), .CNT_W(CNT_W),
        .SETUP_CYC(SETUP_CYC), .OE_CYC(OE_CYC), .FLT_CYC(FLT_CYC)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_sig(req_sig),
        .req_ready(req_ready),
        .timer_done(t_done), .timer_load(t_load), .timer_val(t_val),
        .sel_open(sel_open), .sel_close(sel_close), .sel_idx(sel_idx),
        .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .id_volt_req(id_volt_req),
        .mem_data(mem_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    eprom_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    eprom_rd_ce_decode #(.NDEV(NDEV), .SEL_W(SEL_W)) u_dec (
        .clk(clk), .rst(rst), .open(sel_open), .close(sel_close),
        .sel(sel_idx), .ce_n(mem_ce_n)
    );

    // Window counters for the timing checks below
    logic             any_ce;
    logic [CNT_W-1:0] ce_lo_cnt, en_hi_cnt;
    assign any_ce = !(&mem_ce_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_lo_cnt <= '0;
            en_hi_cnt <= CNT_W'(FLT_CYC);
        end else begin
            if (!any_ce)
                ce_lo_cnt <= '0;
            else if (ce_lo_cnt < CNT_W'(SETUP_CYC))
                ce_lo_cnt <= ce_lo_cnt + 1'b1;
            if (any_ce || !mem_oe_n)
                en_hi_cnt <= '0;
            else if (en_hi_cnt < CNT_W'(FLT_CYC))
                en_hi_cnt <= en_hi_cnt + 1'b1;
        end
    end

    a_r7_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> any_ce);

    a_r5_oe_after_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> ($past(ce_lo_cnt) >= CNT_W'(SETUP_CYC - 1)));

    a_r8_float_gap: assert property (@(posedge clk) disable iff (rst)
        (any_ce && !$past(any_ce)) |-> ($past(en_hi_cnt) >= CNT_W'(FLT_CYC)));

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (any_ce && $past(any_ce)) |-> $stable(mem_addr));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!any_ce && mem_oe_n && !id_volt_req));

    a_r9_hv_in_access: assert property (@(posedge clk) disable iff (rst)
        id_volt_req |-> any_ce);

endmodule

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;
    localparam int CLK = 5;
    localparam int ND  = 4;
    localparam int S   = (120 - 60 + CLK - 1) / CLK + 1;
    localparam int O   = (60 + CLK - 1) / CLK + 1;
    localparam int F   = (50 + CLK - 1) / CLK + 1;
    localparam int END = S + O + 1 + F;
    localparam int NT  = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [20:0] req_addr = '0;
    logic        req_sig = 1'b0;
    logic        req_ready, rsp_valid, mem_oe_n, id_volt_req;
    logic [7:0]  rsp_data, mem_data;
    logic [18:0] mem_addr;
    logic [ND-1:0] mem_ce_n;

    always #2.5 clk = ~clk;

    eprom_rd_ctrl #(.CLK_NS(CLK), .SPEED_SLOW(1'b0), .NDEV(ND)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_sig(req_sig), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_data(mem_data), .id_volt_req(id_volt_req)
    );

    // Behavioural device bank: elapsed-time tracking in ns
    int ce_t = 0, oe_t = 0, a_t = 0;
    logic [18:0] last_addr = '0;

    function automatic logic [7:0] pat(input int d, input logic [18:0] a);
        return a[7:0] ^ a[18:11] ^ 8'(d * 59);
    endfunction

    always @(posedge clk) begin
        ce_t <= (&mem_ce_n) ? 0 : ce_t + CLK;
        oe_t <= mem_oe_n ? 0 : oe_t + CLK;
        a_t  <= (mem_addr != last_addr) ? 0 : a_t + CLK;
        last_addr <= mem_addr;
    end

    always_comb begin
        int sel;
        sel = -1;
        mem_data = 8'h00;
        for (int i = 0; i < ND; i++) if (!mem_ce_n[i]) sel = i;
        if (sel >= 0 && !mem_oe_n) begin
            if (ce_t >= 120 && oe_t >= 60 && a_t >= 120)
                mem_data = id_volt_req ? (mem_addr[0] ? 8'h41 : 8'h20)
                                       : pat(sel, mem_addr);
            else
                mem_data = 8'hEE;
        end
    end

    // Check bookkeeping
    int checks = 0, errors = 0;
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Stimulus list
    int t_dev[NT], t_sig[NT], t_gap[NT], t_junk[NT];
    logic [18:0] t_addr[NT];
    initial begin
        t_dev  = '{0, 3, 1, 2, 0, 2, 3, 1, 0};
        t_addr = '{19'h00000, 19'h7FFFF, 19'h12345, 19'h055AA, 19'h00000,
                   19'h00001, 19'h00000, 19'h3C3C3, 19'h40001};
        t_sig  = '{0, 0, 0, 0, 1, 1, 0, 0, 0};
        t_gap  = '{0, 3, 0, 1, 0, 0, 2, 0, 5};
        t_junk = '{0, 1, 0, 1, 0, 1, 0, 1, 0};
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1", "ce_n", 32'(mem_ce_n), 32'hF);
        chk("R1", "oe_n", 32'(mem_oe_n), 32'h1);
        chk("R1", "ready", 32'(req_ready), 32'h1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1", "id_volt_req", 32'(id_volt_req), 32'h0);
        rst = 1'b0;
    end

    // Reference model, compared on every clock at the falling edge
    bit  busy = 0, done = 0;
    int  k = 0, idx = 0, gap_cnt = 0, cyc = 0;
    int  cur_dev = 0, cur_sig = 0;
    logic [18:0] cur_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [ND-1:0] e_ce;
            logic e_oe, e_rv, e_hv, in_acc;
            cyc++;
            if (busy) k++;
            if (busy && k == END) busy = 0;
            in_acc = busy && k <= S + O;
            e_ce = in_acc ? ~(ND'(1) << cur_dev) : '1;
            e_oe = !(busy && k >= S && k <= S + O);
            e_rv = busy && k == S + O + 1;
            e_hv = in_acc && cur_sig != 0;
            chk("R3", "ce_n", 32'(mem_ce_n), 32'(e_ce));
            chk("R5", "oe_n", 32'(mem_oe_n), 32'(e_oe));
            chk("R7", "oe_low_implies_ce_low", 32'(!mem_oe_n && (&mem_ce_n)), 32'h0);
            chk("R6", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
            chk("R9", "id_volt_req", 32'(id_volt_req), 32'(e_hv));
            if (busy && k > S + O)
                chk("R8", "ready_in_float", 32'(req_ready), 32'h0);
            else
                chk("R2", "ready", 32'(req_ready), 32'(!busy));
            if (in_acc)
                chk("R4", "mem_addr", 32'(mem_addr), 32'(cur_addr));
            if (e_rv) begin
                if (cur_sig != 0)
                    chk("R9", "signature", 32'(rsp_data),
                        cur_addr[0] ? 32'h41 : 32'h20);
                else
                    chk("R6", "rsp_data", 32'(rsp_data), 32'(pat(cur_dev, cur_addr)));
            end
            // drive the next edge
            if (busy) begin
                req_valid = (t_junk[idx-1] != 0);
                req_addr  = ~{2'(cur_dev), cur_addr};
                req_sig   = 1'b0;
            end else if (gap_cnt > 0) begin
                gap_cnt--;
                req_valid = 1'b0;
            end else if (idx < NT) begin
                cur_dev   = t_dev[idx];
                cur_addr  = t_addr[idx];
                cur_sig   = t_sig[idx];
                req_valid = 1'b1;
                req_addr  = {2'(cur_dev), cur_addr};
                req_sig   = 1'(cur_sig);
                busy = 1;
                k = -1;
                idx++;
                if (idx < NT) gap_cnt = t_gap[idx];
            end else begin
                req_valid = 1'b0;
                done = 1;
            end
            if (done || cyc > 20000) begin
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule